// File: doc/BRIEF.md
# Four-Way Set-Associative Instruction Cache

This block is a read-only code cache placed between a processor fetch port and a slower backing memory. It holds 64 sets of four 32-byte lines, 8 KB in all. A fetch compares its tag against the four ways of its set at the same time. On a hit it returns the word in the same cycle. On a miss it chooses a victim way, fills the whole line with eight one-word memory reads, and then returns the requested word.

The victim comes from one of two sources, chosen per miss by a mode input. One is a 2-bit round-robin counter kept for each set. The other is a 32-bit shift-and-xor generator shared by all sets. Two maintenance commands are provided: flush every line, or drop the single line that holds a given address. A command that arrives during a fill is held until the fill ends. With the enable input low, fetches go straight to memory and nothing is allocated.

The controller has four states:
- `ST_IDLE` applies pending maintenance, serves hits, and starts misses or bypass reads. It goes to `ST_FILL` on a miss and to `ST_BYPASS` when the cache is disabled.
- `ST_FILL` issues the eight line reads. It goes to `ST_REPLY` after the last read is accepted.
- `ST_REPLY` returns the captured word and goes back to `ST_IDLE`.
- `ST_BYPASS` makes a single memory read and goes back to `ST_IDLE` when that read is accepted.

Top module: `icache_top`

## Requirements
- R1: The fetch address is split into tag [31:11], set [10:5] and word [4:2]. When the cache is enabled, a hit with no maintenance pending raises `fetch_ready` with the stored word in the cycle the request is presented, and makes no memory access.
- R2: A miss makes exactly eight memory reads. They start at the 32-byte-aligned line address and step by 4. `fetch_ready` rises in the cycle after the last read is accepted, carrying the requested word, and the line then hits.
- R3: With `rr_mode`=1, the victim is the current value of the set's 2-bit counter. The counter then advances by one, modulo 4, on that miss.
- R4: With `rr_mode`=0, each miss replaces the generator state s with s ^ (s*17) ^ (s*7), taken modulo 2^32. The victim is bits [18:17] of the new state.
- R5: Reset sets the generator state to 44203, clears every counter and valid bit, and holds `fetch_ready` and `mem_valid` low.
- R6: A one-cycle pulse on `inv_all` clears all 256 lines, so every later fetch misses.
- R7: A pulse on `inv_line` clears only the way in the addressed set whose tag matches `inv_line_addr`. If no way matches, nothing changes.
- R8: Maintenance pulsed during a fill takes effect only after that fill completes, so the filled line is invalidated too. Maintenance pulsed while idle is applied on the following cycle, and no fetch is served in that cycle.
- R9: With `cache_en`=0, a fetch makes one memory read at the word-aligned fetch address and returns its data in the cycle it is accepted. No line is allocated.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid` and `mem_addr` stay unchanged on the next cycle.
- R11: `fetch_ready` is only high while `fetch_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | 1 = cache in use, 0 = bypass to memory |
| rr_mode | input | 1 | 1 = round-robin victim, 0 = generator victim |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | 32 | Fetched word, valid with `fetch_ready` |
| inv_all | input | 1 | Pulse: invalidate whole cache |
| inv_line | input | 1 | Pulse: invalidate line matching `inv_line_addr` |
| inv_line_addr | input | 32 | Address for line invalidation |
| mem_valid | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory word address |
| mem_ready | input | 1 | Memory accepts the read, data valid this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench drives conflict traffic into a handful of sets, so that eviction order decides which later fetches hit. A wrong counter step, or victim bits taken from the old generator state instead of the new one, shows up as a hit where eight reads were expected, or the reverse. Flushes issued during a fill catch a design that applies them at once: the freshly filled line would wrongly survive. Line invalidation of a non-resident address catches a design that drops some other way. Bypass fetches catch a design that allocates lines or issues a full line read while disabled.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int unsigned IC_ADDR_W     = 32;
    localparam int unsigned IC_DATA_W     = 32;
    localparam int unsigned IC_SETS       = 64;
    localparam int unsigned IC_WAYS       = 4;
    localparam int unsigned IC_LINE_WORDS = 8;
    localparam int unsigned IC_BYTE_W     = 2;
    localparam int unsigned IC_SET_W      = $clog2(IC_SETS);
    localparam int unsigned IC_WAY_W      = $clog2(IC_WAYS);
    localparam int unsigned IC_WOFF_W     = $clog2(IC_LINE_WORDS);
    localparam int unsigned IC_TAG_W      = IC_ADDR_W - IC_SET_W - IC_WOFF_W - IC_BYTE_W;
    localparam logic [31:0] IC_SEED_INIT  = 32'd44203;
    localparam int unsigned IC_RAND_LSB   = 17;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_REPLY,
        ST_BYPASS
    } ic_state_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags import icache_pkg::*; #(
    parameter int unsigned SETS  = IC_SETS,
    parameter int unsigned WAYS  = IC_WAYS,
    parameter int unsigned TAG_W = IC_TAG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  lk_set,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic [WAYS-1:0]          lk_hit,
    input  logic                     clr_all,
    input  logic                     clr_match,
    input  logic                     wr_en,
    input  logic [$clog2(SETS)-1:0]  wr_set,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic [TAG_W-1:0]         wr_tag
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  hit_first;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_hit[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign hit_first = lk_hit & (~lk_hit + 1'b1);

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else begin
            if (clr_all) begin
                for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
            end else if (clr_match) begin
                vld_q[lk_set] <= vld_q[lk_set] & ~hit_first;
            end
            if (wr_en) vld_q[wr_set][wr_way] <= 1'b1;
        end
    end
endmodule

// File: rtl/icache_data.sv
module icache_data import icache_pkg::*; #(
    parameter int unsigned DEPTH  = IC_SETS * IC_WAYS * IC_LINE_WORDS,
    parameter int unsigned DATA_W = IC_DATA_W
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/icache_victim.sv
module icache_victim import icache_pkg::*; #(
    parameter int unsigned SETS      = IC_SETS,
    parameter int unsigned WAYS      = IC_WAYS,
    parameter logic [31:0] SEED_INIT = IC_SEED_INIT,
    parameter int unsigned RAND_LSB  = IC_RAND_LSB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rr_mode,
    input  logic [$clog2(SETS)-1:0] set_idx,
    input  logic                    advance,
    output logic [$clog2(WAYS)-1:0] victim
);
    localparam int unsigned WAY_W = $clog2(WAYS);

    logic [31:0]      seed_q;
    logic [31:0]      seed_nx;
    logic [WAY_W-1:0] cnt_q [SETS];

    assign seed_nx = seed_q ^ (seed_q * 32'd17) ^ (seed_q * 32'd7);
    assign victim  = rr_mode ? cnt_q[set_idx] : seed_nx[RAND_LSB +: WAY_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= SEED_INIT;
            for (int s = 0; s < SETS; s++) cnt_q[s] <= '0;
        end else if (advance) begin
            if (rr_mode) cnt_q[set_idx] <= cnt_q[set_idx] + 1'b1;
            else         seed_q         <= seed_nx;
        end
    end
endmodule

// File: rtl/icache_top.sv
module icache_top import icache_pkg::*; #(
    parameter int unsigned SETS       = IC_SETS,
    parameter int unsigned WAYS       = IC_WAYS,
    parameter int unsigned LINE_WORDS = IC_LINE_WORDS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cache_en,
    input  logic        rr_mode,
    input  logic        fetch_req,
    input  logic [31:0] fetch_addr,
    output logic        fetch_ready,
    output logic [31:0] fetch_data,
    input  logic        inv_all,
    input  logic        inv_line,
    input  logic [31:0] inv_line_addr,
    output logic        mem_valid,
    output logic [31:0] mem_addr,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata
);
    localparam int unsigned SET_W  = $clog2(SETS);
    localparam int unsigned WAY_W  = $clog2(WAYS);
    localparam int unsigned WOFF_W = $clog2(LINE_WORDS);
    localparam int unsigned TAG_W  = 32 - SET_W - WOFF_W - IC_BYTE_W;
    localparam int unsigned DEPTH  = SETS * WAYS * LINE_WORDS;
    localparam int unsigned IDX_W  = SET_W + WAY_W + WOFF_W;
    localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(LINE_WORDS - 1);

    ic_state_e state_q, state_d;

    logic              pend_all_q, pend_line_q;
    logic [31:0]       pend_addr_q;
    logic              apply;
    logic [31:0]       lk_addr;
    logic [SET_W-1:0]  f_set;
    logic [TAG_W-1:0]  f_tag;
    logic [WOFF_W-1:0] f_word;
    logic [WAYS-1:0]   hit_vec;
    logic              hit_any;
    logic [WAY_W-1:0]  hit_way;
    logic              miss_go;
    logic [WAY_W-1:0]  victim;

    logic [SET_W-1:0]  fill_set_q;
    logic [TAG_W-1:0]  fill_tag_q;
    logic [WAY_W-1:0]  fill_way_q;
    logic [WOFF_W-1:0] fill_word_q;
    logic [WOFF_W-1:0] fill_cnt_q;
    logic [31:0]       reply_q;

    logic              fill_beat;
    logic              fill_done;
    logic [31:0]       rd_word;

    // Address fields
    assign f_set  = fetch_addr[IC_BYTE_W + WOFF_W +: SET_W];
    assign f_tag  = fetch_addr[31 -: TAG_W];
    assign f_word = fetch_addr[IC_BYTE_W +: WOFF_W];

    assign apply   = (state_q == ST_IDLE) && (pend_all_q || pend_line_q);
    assign lk_addr = pend_line_q ? pend_addr_q : fetch_addr;
    assign hit_any = |hit_vec;
    assign miss_go = (state_q == ST_IDLE) && !apply && fetch_req && cache_en && !hit_any;

    assign fill_beat = (state_q == ST_FILL) && mem_ready;
    assign fill_done = fill_beat && (fill_cnt_q == LAST_WORD);

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    icache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (lk_addr[IC_BYTE_W + WOFF_W +: SET_W]),
        .lk_tag    (lk_addr[31 -: TAG_W]),
        .lk_hit    (hit_vec),
        .clr_all   (apply && pend_all_q),
        .clr_match (apply && pend_line_q),
        .wr_en     (fill_done),
        .wr_set    (fill_set_q),
        .wr_way    (fill_way_q),
        .wr_tag    (fill_tag_q)
    );

    icache_data #(.DEPTH(DEPTH), .DATA_W(32)) u_data (
        .clk     (clk),
        .wr_en   (fill_beat),
        .wr_idx  (IDX_W'({fill_set_q, fill_way_q, fill_cnt_q})),
        .wr_data (mem_rdata),
        .rd_idx  (IDX_W'({f_set, hit_way, f_word})),
        .rd_data (rd_word)
    );

    icache_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .rr_mode (rr_mode),
        .set_idx (f_set),
        .advance (miss_go),
        .victim  (victim)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!apply && fetch_req) begin
                    if (!cache_en)     state_d = ST_BYPASS;
                    else if (!hit_any) state_d = ST_FILL;
                end
            end
            ST_FILL:   if (fill_done) state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            ST_BYPASS: if (mem_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        fetch_ready = 1'b0;
        fetch_data  = '0;
        mem_valid   = 1'b0;
        mem_addr    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (!apply && fetch_req && cache_en && hit_any) begin
                    fetch_ready = 1'b1;
                    fetch_data  = rd_word;
                end
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {fill_tag_q, fill_set_q, fill_cnt_q, {IC_BYTE_W{1'b0}}};
            end
            ST_REPLY: begin
                fetch_ready = 1'b1;
                fetch_data  = reply_q;
            end
            ST_BYPASS: begin
                mem_valid   = 1'b1;
                mem_addr    = {fetch_addr[31:IC_BYTE_W], {IC_BYTE_W{1'b0}}};
                fetch_ready = mem_ready;
                fetch_data  = mem_rdata;
            end
            default: ;
        endcase
    end

    // Fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_set_q  <= '0;
            fill_tag_q  <= '0;
            fill_way_q  <= '0;
            fill_word_q <= '0;
            fill_cnt_q  <= '0;
            reply_q     <= '0;
        end else begin
            if (miss_go) begin
                fill_set_q  <= f_set;
                fill_tag_q  <= f_tag;
                fill_word_q <= f_word;
                fill_way_q  <= victim;
                fill_cnt_q  <= '0;
            end else if (fill_beat) begin
                fill_cnt_q <= fill_cnt_q + 1'b1;
            end
            if (fill_beat && (fill_cnt_q == fill_word_q)) reply_q <= mem_rdata;
        end
    end

    // Pending maintenance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_all_q  <= 1'b0;
            pend_line_q <= 1'b0;
            pend_addr_q <= '0;
        end else begin
            pend_all_q  <= (pend_all_q && !apply) || inv_all;
            pend_line_q <= (pend_line_q && !apply) || inv_line;
            if (inv_line) pend_addr_q <= inv_line_addr;
        end
    end
endmodule

// File: rtl/icache_chk.sv
module icache_chk import icache_pkg::*; (
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_req,
    input logic        fetch_ready,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input ic_state_e   state
);
    localparam logic [IC_WOFF_W-1:0] LASTW = IC_WOFF_W'(IC_LINE_WORDS - 1);

    // R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    // R11
    ready_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> fetch_req);

    // R2
    fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && $past(state) != ST_FILL) |-> (mem_addr[IC_BYTE_W +: IC_WOFF_W] == '0));

    // R2
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ready && mem_addr[IC_BYTE_W +: IC_WOFF_W] != LASTW)
        |=> (state == ST_FILL && mem_addr == $past(mem_addr) + 32'd4));

    // R2
    fill_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ready && mem_addr[IC_BYTE_W +: IC_WOFF_W] == LASTW)
        |=> (fetch_ready && !mem_valid));

    // R9
    bypass_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS && mem_ready) |-> fetch_ready);
endmodule

bind icache_top icache_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_ready (fetch_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .state       (state_q)
);

// File: tb/sim_icache_top.sv
module sim_icache_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cache_en, rr_mode, fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        inv_all, inv_line;
    logic [31:0] inv_line_addr;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic        mem_ready;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;

    // model state
    logic [20:0] m_tag [64][4];
    bit          m_vld [64][4];
    logic [1:0]  m_cnt [64];
    logic [31:0] m_seed;

    always #5 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'hA5A50F0F;
    endfunction

    function automatic logic [31:0] gen_next(input logic [31:0] s);
        return s ^ (s * 32'd17) ^ (s * 32'd7);
    endfunction

    function automatic logic [31:0] mk(input int tg, input int st, input int wd);
        return {21'(tg), 6'(st), 3'(wd), 2'b00};
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    icache_top u0 (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .rr_mode(rr_mode),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_data(fetch_data), .inv_all(inv_all), .inv_line(inv_line),
        .inv_line_addr(inv_line_addr), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 64; s++) begin
            m_cnt[s] = 2'd0;
            for (int w = 0; w < 4; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        m_seed = 32'd44203;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cache_en = 1'b1; rr_mode = 1'b1; fetch_req = 1'b0;
        fetch_addr = '0; inv_all = 1'b0; inv_line = 1'b0; inv_line_addr = '0;
        mem_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // entry and exit at a falling edge
    task automatic do_fetch(input logic [31:0] a, input bit en, input bit rr,
                            input bit inv_mid, input string req);
        int st = int'(a[10:5]);
        logic [20:0] tg = a[31:11];
        bit hit = 1'b0;
        int hs = 0;
        bit done = 1'b0;
        logic [31:0] first = '0;
        logic [31:0] got = '0;
        int exp_hs;
        for (int w = 0; w < 4; w++) if (m_vld[st][w] && m_tag[st][w] == tg) hit = 1'b1;
        exp_hs = !en ? 1 : (hit ? 0 : 8);
        cache_en = en; rr_mode = rr; fetch_req = 1'b1; fetch_addr = a;
        for (int cyc = 0; cyc < 300 && !done; cyc++) begin
            inv_all = (inv_mid && cyc == 2);
            mem_ready = ($urandom_range(3) != 0);
            #2;
            if (mem_valid && mem_ready) begin
                if (hs == 0) first = mem_addr;
                hs++;
            end
            if (fetch_ready) begin got = fetch_data; done = 1'b1; end
            @(posedge clk); @(negedge clk);
        end
        fetch_req = 1'b0; inv_all = 1'b0; mem_ready = 1'b0;
        chk(done, req, "fetch completed", 32'(done), 32'd1);
        chk(got == mem_word(a), req, "fetch data", got, mem_word(a));
        chk(hs == exp_hs, req, "memory reads", 32'(hs), 32'(exp_hs));
        if (!en) chk(first == {a[31:2], 2'b00}, req, "bypass address", first, {a[31:2], 2'b00});
        else if (!hit) chk(first == {a[31:5], 5'b0}, req, "fill start address", first, {a[31:5], 5'b0});
        if (en && !hit) begin
            int v;
            if (rr) begin v = int'(m_cnt[st]); m_cnt[st] = m_cnt[st] + 2'd1; end
            else begin m_seed = gen_next(m_seed); v = int'(m_seed[18:17]); end
            m_tag[st][v] = tg; m_vld[st][v] = 1'b1;
        end
        if (inv_mid) for (int s = 0; s < 64; s++) for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
    endtask

    task automatic do_inv(input bit all, input logic [31:0] a);
        inv_all = all; inv_line = !all; inv_line_addr = a;
        @(posedge clk); @(negedge clk);
        inv_all = 1'b0; inv_line = 1'b0;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        if (all) begin
            for (int s = 0; s < 64; s++) for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
        end else begin
            int st = int'(a[10:5]);
            bit found = 1'b0;
            for (int w = 0; w < 4; w++)
                if (!found && m_vld[st][w] && m_tag[st][w] == a[31:11]) begin
                    m_vld[st][w] = 1'b0; found = 1'b1;
                end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        #2;
        // R5, R11: quiet outputs after reset
        chk(!fetch_ready && !mem_valid, "R5", "outputs after reset",
            {30'd0, fetch_ready, mem_valid}, 32'd0);
        @(negedge clk);

        // R2 then R1: miss fills, repeat hits on other words
        do_fetch(mk(3, 5, 6), 1, 1, 0, "R2");
        do_fetch(mk(3, 5, 6), 1, 1, 0, "R1");
        do_fetch(mk(3, 5, 0), 1, 1, 0, "R1");
        do_fetch(mk(3, 5, 7), 1, 1, 0, "R1");

        // R3: round-robin eviction order within one set
        for (int t = 1; t <= 4; t++) do_fetch(mk(10 + t, 9, t), 1, 1, 0, "R3");
        do_fetch(mk(11, 9, 2), 1, 1, 0, "R3");
        do_fetch(mk(12, 9, 0), 1, 1, 0, "R3");

        // R4, R5: generator victim from a fresh reset
        do_reset();
        for (int t = 0; t < 7; t++) do_fetch(mk(20 + t, 2, t), 1, 0, 0, "R4");
        for (int t = 0; t < 7; t++) do_fetch(mk(20 + t, 2, 7 - t), 1, 0, 0, "R4");

        // R7: line invalidation, hit and no-hit
        do_fetch(mk(40, 7, 1), 1, 1, 0, "R7");
        do_fetch(mk(41, 7, 1), 1, 1, 0, "R7");
        do_inv(0, mk(40, 7, 3));
        do_fetch(mk(41, 7, 4), 1, 1, 0, "R7");
        do_inv(0, mk(99, 7, 0));
        do_fetch(mk(41, 7, 5), 1, 1, 0, "R7");
        do_fetch(mk(40, 7, 2), 1, 1, 0, "R7");

        // R6: flush all
        do_inv(1, '0);
        do_fetch(mk(41, 7, 5), 1, 1, 0, "R6");
        do_fetch(mk(3, 5, 6), 1, 1, 0, "R6");

        // R8: flush during fill is deferred, filled line is dropped
        do_fetch(mk(50, 11, 3), 1, 1, 1, "R8");
        do_fetch(mk(50, 11, 3), 1, 1, 0, "R8");
        do_fetch(mk(3, 5, 6), 1, 1, 0, "R8");

        // R9: bypass, no allocation
        do_fetch(mk(60, 13, 2), 0, 1, 0, "R9");
        do_fetch(mk(60, 13, 2), 0, 1, 0, "R9");
        do_fetch(mk(60, 13, 2), 1, 1, 0, "R9");

        // random traffic over a few sets
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom_range(99));
            logic [31:0] a = mk(int'($urandom_range(6)), int'($urandom_range(3)),
                                int'($urandom_range(7)));
            if (r < 3) do_inv(1, '0);
            else if (r < 8) do_inv(0, a);
            else begin
                bit en = ($urandom_range(9) != 0);
                bit rr = $urandom_range(1) != 0;
                do_fetch(a, en, rr, 0, !en ? "R9" : "R1");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule